// File: doc/BRIEF.md
# Signed Saturating Arithmetic Unit

This block is the saturating arithmetic stage of a processor execution pipeline. It takes an operation code, two signed data words and the current sticky saturation flag. It returns the clamped result and the updated sticky flag one clock later. There are four full-word operations: add, subtract, and the two doubling forms. It also has lane-wise add and subtract on two halfwords or on four bytes, and two forms that cross the halfwords of the operands.

Each lane and each word step is computed one bit wider than its operand. When the two top bits of that wide value differ, the step clamps to the most positive or most negative value of its width. Only the full-word forms can raise the sticky flag. No operation clears it. The lane forms carry the flag through unchanged, so the caller can keep one flag for a whole instruction stream.

Top module: `sat_alu`

## Requirements
- R1: Word add (code 0) and word subtract (code 1) return the signed sum or difference of `opnd_a` and `opnd_b`, clamped to 0x80000000..0x7FFFFFFF.
- R2: A full-word operation (codes 0 to 3) that clamps drives `sat_out` to 1. If it does not clamp, `sat_out` equals `sat_in`. When `sat_in` is 1, `sat_out` is 1 for every operation code.
- R3: Doubling add (code 2) first clamps `opnd_b + opnd_b`, then clamps `opnd_a` plus that value. `sat_out` is set if either step clamps.
- R4: Doubling subtract (code 3) first clamps `opnd_b + opnd_b`, then clamps `opnd_a` minus that value. `sat_out` is set if either step clamps.
- R5: Halfword add (code 4) and halfword subtract (code 5) work on bits 31:16 and bits 15:0 independently. Each lane is clamped to -32768..32767, and `sat_out` equals `sat_in`.
- R6: Byte add (code 6) and byte subtract (code 7) work on the four 8-bit lanes independently. Each lane is clamped to -128..127, and `sat_out` equals `sat_in`.
- R7: Exchange add-subtract (code 8) puts the clamped value of a[15:0] - b[31:16] in bits 15:0. It puts the clamped value of a[31:16] + b[15:0] in bits 31:16. `sat_out` equals `sat_in`.
- R8: Exchange subtract-add (code 9) puts the clamped value of a[15:0] + b[31:16] in bits 15:0. It puts the clamped value of a[31:16] - b[15:0] in bits 31:16. `sat_out` equals `sat_in`.
- R9: Codes 10 to 15 return a result of zero, and `sat_out` equals `sat_in`.
- R10: `result` and `sat_out` are registered and appear on the clock edge after the inputs are sampled. While `rst_n` is low, both are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_in | input | 1 | Current sticky saturation flag |
| result | output | 32 | Clamped result, registered |
| sat_out | output | 1 | Updated sticky saturation flag, registered |

## Verification
The bench builds the unit with its default 32-bit data width and 4-bit operation code. This places the word clamp boundaries at 0x7FFFFFFF and 0x80000000, the halfword lanes at 0x7FFF and 0x8000, and the byte lanes at 0x7F and 0x80. The vectors drive every defined code and one reserved code. They cover a doubling step that clamps only in its first stage and another that clamps only in its second stage. They also cover lanes that clamp in opposite directions within one word, and a set incoming flag passing through a lane operation.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              sat_in,
  output logic [DATA_W-1:0] result,
  output logic              sat_out
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  localparam logic [OPC_W-1:0] OP_WADD  = OPC_W'(0);
  localparam logic [OPC_W-1:0] OP_WSUB  = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_DADD  = OPC_W'(2);
  localparam logic [OPC_W-1:0] OP_DSUB  = OPC_W'(3);
  localparam logic [OPC_W-1:0] OP_HADD  = OPC_W'(4);
  localparam logic [OPC_W-1:0] OP_HSUB  = OPC_W'(5);
  localparam logic [OPC_W-1:0] OP_BADD  = OPC_W'(6);
  localparam logic [OPC_W-1:0] OP_BSUB  = OPC_W'(7);
  localparam logic [OPC_W-1:0] OP_XADSB = OPC_W'(8);
  localparam logic [OPC_W-1:0] OP_XSBAD = OPC_W'(9);

  function automatic logic [DATA_W:0] sat_w(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                            input logic sub);
    logic [DATA_W:0] w;
    w = sub ? ({x[DATA_W-1], x} - {y[DATA_W-1], y}) : ({x[DATA_W-1], x} + {y[DATA_W-1], y});
    if (w[DATA_W] != w[DATA_W-1]) sat_w = {1'b1, w[DATA_W], {(DATA_W-1){~w[DATA_W]}}};
    else                          sat_w = {1'b0, w[DATA_W-1:0]};
  endfunction

  function automatic logic [HALF_W-1:0] sat_h(input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] y,
                                              input logic sub);
    logic [HALF_W:0] w;
    w = sub ? ({x[HALF_W-1], x} - {y[HALF_W-1], y}) : ({x[HALF_W-1], x} + {y[HALF_W-1], y});
    if (w[HALF_W] != w[HALF_W-1]) sat_h = {w[HALF_W], {(HALF_W-1){~w[HALF_W]}}};
    else                          sat_h = w[HALF_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] sat_b(input logic [BYTE_W-1:0] x, input logic [BYTE_W-1:0] y,
                                              input logic sub);
    logic [BYTE_W:0] w;
    w = sub ? ({x[BYTE_W-1], x} - {y[BYTE_W-1], y}) : ({x[BYTE_W-1], x} + {y[BYTE_W-1], y});
    if (w[BYTE_W] != w[BYTE_W-1]) sat_b = {w[BYTE_W], {(BYTE_W-1){~w[BYTE_W]}}};
    else                          sat_b = w[BYTE_W-1:0];
  endfunction

  logic [DATA_W:0] w_add, w_sub, w_dbl, w_dadd, w_dsub;

  assign w_add  = sat_w(opnd_a, opnd_b, 1'b0);
  assign w_sub  = sat_w(opnd_a, opnd_b, 1'b1);
  assign w_dbl  = sat_w(opnd_b, opnd_b, 1'b0);
  assign w_dadd = sat_w(opnd_a, w_dbl[DATA_W-1:0], 1'b0);
  assign w_dsub = sat_w(opnd_a, w_dbl[DATA_W-1:0], 1'b1);

  logic [DATA_W-1:0] h_add, h_sub, b_add, b_sub, x_adsb, x_sbad;

  for (genvar i = 0; i < 2; i++) begin : g_half
    assign h_add[i*HALF_W +: HALF_W] = sat_h(opnd_a[i*HALF_W +: HALF_W], opnd_b[i*HALF_W +: HALF_W], 1'b0);
    assign h_sub[i*HALF_W +: HALF_W] = sat_h(opnd_a[i*HALF_W +: HALF_W], opnd_b[i*HALF_W +: HALF_W], 1'b1);
    // lane i of operand a pairs with the opposite lane of operand b; low lane subtracts for code 8
    assign x_adsb[i*HALF_W +: HALF_W] = sat_h(opnd_a[i*HALF_W +: HALF_W], opnd_b[(1-i)*HALF_W +: HALF_W], i == 0);
    assign x_sbad[i*HALF_W +: HALF_W] = sat_h(opnd_a[i*HALF_W +: HALF_W], opnd_b[(1-i)*HALF_W +: HALF_W], i == 1);
  end

  for (genvar i = 0; i < 4; i++) begin : g_byte
    assign b_add[i*BYTE_W +: BYTE_W] = sat_b(opnd_a[i*BYTE_W +: BYTE_W], opnd_b[i*BYTE_W +: BYTE_W], 1'b0);
    assign b_sub[i*BYTE_W +: BYTE_W] = sat_b(opnd_a[i*BYTE_W +: BYTE_W], opnd_b[i*BYTE_W +: BYTE_W], 1'b1);
  end

  logic [DATA_W-1:0] nxt_res;
  logic              nxt_sat;

  always_comb begin
    nxt_sat = sat_in;
    case (op_sel)
      OP_WADD:  begin nxt_res = w_add[DATA_W-1:0];  nxt_sat = sat_in | w_add[DATA_W]; end
      OP_WSUB:  begin nxt_res = w_sub[DATA_W-1:0];  nxt_sat = sat_in | w_sub[DATA_W]; end
      OP_DADD:  begin nxt_res = w_dadd[DATA_W-1:0]; nxt_sat = sat_in | w_dbl[DATA_W] | w_dadd[DATA_W]; end
      OP_DSUB:  begin nxt_res = w_dsub[DATA_W-1:0]; nxt_sat = sat_in | w_dbl[DATA_W] | w_dsub[DATA_W]; end
      OP_HADD:  nxt_res = h_add;
      OP_HSUB:  nxt_res = h_sub;
      OP_BADD:  nxt_res = b_add;
      OP_BSUB:  nxt_res = b_sub;
      OP_XADSB: nxt_res = x_adsb;
      OP_XSBAD: nxt_res = x_sbad;
      default:  nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      sat_out <= 1'b0;
    end else begin
      result  <= nxt_res;
      sat_out <= nxt_sat;
    end
  end

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              sat_in,
  input logic [DATA_W-1:0] result,
  input logic              sat_out
);

  // R10
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (result == '0 && !sat_out));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) sat_in |=> sat_out);

  // R5
  lane_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= OPC_W'(4) && op_sel <= OPC_W'(9)) |=> (sat_out == $past(sat_in)));

  // R1
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OPC_W'(0) && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1]) |=> !result[DATA_W-1]);

  // R1
  sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OPC_W'(1) && opnd_a[DATA_W-1] && !opnd_b[DATA_W-1]) |=> result[DATA_W-1]);

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OPC_W'(9)) |=> (result == '0 && sat_out == $past(sat_in)));

endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/test_sat_alu.sv
module test_sat_alu;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        qi;
    logic [31:0] r;
    logic        qo;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R1 word add, positive clamp; R2 flag set
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b1, 4'd1},
    '{4'd0, 32'h00000005, 32'hFFFFFFFD, 1'b0, 32'h00000002, 1'b0, 4'd1},
    '{4'd0, 32'h80000000, 32'hFFFFFFFF, 1'b0, 32'h80000000, 1'b1, 4'd1},
    '{4'd1, 32'h80000000, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 4'd1},
    '{4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h7FFFFFFF, 1'b1, 4'd1},
    // R2 sticky flag kept with no clamp
    '{4'd1, 32'h00000010, 32'h00000003, 1'b1, 32'h0000000D, 1'b1, 4'd2},
    // R3 doubling add: both steps clamp, none, second only
    '{4'd2, 32'h00000001, 32'h40000000, 1'b0, 32'h7FFFFFFF, 1'b1, 4'd3},
    '{4'd2, 32'h00000010, 32'h00000008, 1'b0, 32'h00000020, 1'b0, 4'd3},
    '{4'd2, 32'h80000000, 32'hC0000000, 1'b0, 32'h80000000, 1'b1, 4'd3},
    // R4 doubling subtract: second only, none, first only
    '{4'd3, 32'h00000000, 32'hC0000000, 1'b0, 32'h7FFFFFFF, 1'b1, 4'd4},
    '{4'd3, 32'h00000100, 32'h00000040, 1'b0, 32'h00000080, 1'b0, 4'd4},
    '{4'd3, 32'hFFFFFFFF, 32'h40000000, 1'b0, 32'h80000000, 1'b1, 4'd4},
    // R5 halfword lanes
    '{4'd4, 32'h7FFF8000, 32'h0001FFFF, 1'b0, 32'h7FFF8000, 1'b0, 4'd5},
    '{4'd4, 32'h12340010, 32'h0001FFF0, 1'b1, 32'h12350000, 1'b1, 4'd5},
    '{4'd5, 32'h80000005, 32'h00010007, 1'b0, 32'h8000FFFE, 1'b0, 4'd5},
    // R6 byte lanes
    '{4'd6, 32'h7F8010F0, 32'h01FF10F0, 1'b0, 32'h7F8020E0, 1'b0, 4'd6},
    '{4'd7, 32'h807F0500, 32'h01FF0680, 1'b0, 32'h807FFF7F, 1'b0, 4'd7 - 4'd1},
    // R7 exchange add-subtract
    '{4'd8, 32'h01000200, 32'h00100003, 1'b0, 32'h010301F0, 1'b0, 4'd7},
    // R8 exchange subtract-add, plain and clamping
    '{4'd9, 32'h01000200, 32'h00100003, 1'b0, 32'h00FD0210, 1'b0, 4'd8},
    '{4'd9, 32'h80007FFF, 32'h00010001, 1'b0, 32'h80007FFF, 1'b0, 4'd8},
    // R9 reserved code
    '{4'd15, 32'h00001234, 32'h00005678, 1'b1, 32'h00000000, 1'b1, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        sat_in = 1'b0;
  logic [31:0] result;
  logic        sat_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sat_alu i_sat_alu (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sat_in(sat_in), .result(result), .sat_out(sat_out)
  );

  task automatic check(input string req, input logic [31:0] er, input logic eq);
    checks++;
    if (result !== er || sat_out !== eq) begin
      errors++;
      $display("FAIL %s: result=%h sat=%b expected result=%h sat=%b", req, result, sat_out, er, eq);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input logic q);
    op_sel = op; opnd_a = a; opnd_b = b; sat_in = q;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 32'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].qi);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].r, VECS[i].qo);
    end

    // R10 latency: new inputs do not reach the outputs before the edge
    @(negedge clk);
    apply(4'd0, 32'h00000003, 32'h00000004, 1'b0);
    @(negedge clk);
    check("R10 first", 32'h00000007, 1'b0);
    apply(4'd0, 32'h00000010, 32'h00000001, 1'b1);
    #1 check("R10 hold", 32'h00000007, 1'b0);
    @(negedge clk);
    check("R10 update", 32'h00000011, 1'b1);

    // R2 sticky flag passes through a lane operation that clamps
    apply(4'd6, 32'h7F7F7F7F, 32'h7F7F7F7F, 1'b1);
    @(negedge clk);
    check("R2 lane pass", 32'h7F7F7F7F, 1'b1);

    // R10 reset in mid-run clears both outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", 32'h0, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule